// File: doc/BRIEF.md
# Min/Max/Average Integer Execute Stage

This block is the execute stage for four register-to-register integer operations: unsigned maximum, signed minimum, unsigned minimum and a rounding average. It receives a 32-bit instruction word together with two 64-bit source operand values. It decodes the instruction, computes the result, and presents the destination register index and the result to the write-back logic one clock later.

An instruction word that does not match one of the four supported encodings is flagged as illegal. An illegal instruction writes nothing. When the instruction's record bit is set, the stage also produces a 4-bit condition field that describes the result. The summary-overflow bit placed in that field arrives on a plain input. The register file, fetch and exception handling sit outside the block.

Top module: `mmavg_exec_unit`

## Requirements
- R1: Bit numbering is MSB-first, so word bit 0 is `insn[31]`. The primary opcode is `insn[31:26]` and must equal 22. The destination index is `insn[25:21]` and appears on `out_rt`. The extended opcode is `insn[10:1]`. The record bit is `insn[0]`.
- R2: Extended opcode 0011001110 returns the larger of the two operands, compared as unsigned values.
- R3: Extended opcode 0101001110 returns the smaller of the two operands, compared as two's-complement values.
- R4: Extended opcode 0001001110 returns the smaller of the two operands, compared as unsigned values.
- R5: Extended opcode 1101001110 returns bits 64..1 of the 65-bit sum of both zero-extended operands plus one. No carry is lost, so two all-ones operands give all ones.
- R6: For a legal instruction with the record bit at 1, `out_cr_wen` is 1 and `out_cr` = {LT, GT, EQ, SO} in bits 3..0. LT means the result is negative as a signed value. GT means it is positive. EQ means it is zero. SO is a copy of `so_in` taken when the instruction was strobed.
- R7: With the record bit at 0, `out_cr_wen` stays 0.
- R8: Any other primary opcode or extended opcode sets `out_illegal`. In that case `out_wen` and `out_cr_wen` stay 0 and `out_result` is 0.
- R9: A strobe on `in_valid` in cycle N produces `out_valid` and the matching outputs after the clock edge that ends cycle N. Strobes can arrive back to back. In a cycle with no valid output, `out_valid`, `out_wen`, `out_cr_wen` and `out_illegal` are all 0.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_wen`, `out_cr_wen` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | 64 | First source operand value |
| opnd_b | input | 64 | Second source operand value |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Outputs below belong to one strobed instruction |
| out_rt | output | 5 | Destination register index |
| out_result | output | 64 | Operation result |
| out_wen | output | 1 | Register write enable |
| out_illegal | output | 1 | Instruction not recognised |
| out_cr_wen | output | 1 | Condition field write enable |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every result, flag and condition field is due exactly one clock edge after the strobe that carried its instruction. There is no variable latency.

The bench drives inputs at the falling edge. At the next falling edge it compares all outputs with the reference model's prediction for the previous strobe, so the comparison runs on every clock, including back-to-back strobes and idle gaps. In idle cycles only the strobes are checked, and they must all be low.

// File: rtl/mmavg_pkg.sv
package mmavg_pkg;

   localparam int unsigned INSN_W = 32;
   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned XO_W = 10;
   localparam int unsigned CR_W = 4;

   localparam logic [XO_W-1:0] XO_MAXU = 10'b0011001110;
   localparam logic [XO_W-1:0] XO_MINS = 10'b0101001110;
   localparam logic [XO_W-1:0] XO_MINU = 10'b0001001110;
   localparam logic [XO_W-1:0] XO_AVG  = 10'b1101001110;

   typedef enum logic [2:0] {
      OPK_NONE = 3'd0,
      OPK_MAXU = 3'd1,
      OPK_MINS = 3'd2,
      OPK_MINU = 3'd3,
      OPK_AVG  = 3'd4
   } mm_op_e;

   typedef struct packed {
      logic                 legal;
      logic                 rec;
      logic [REG_IDX_W-1:0] rt;
      mm_op_e               op;
   } mm_dec_t;

endpackage

// File: rtl/mmavg_decode.sv
module mmavg_decode
   import mmavg_pkg::*;
#(
   parameter int unsigned PRIMARY_OP = 22
) (
   input  logic [10:0] hi_bits,
   input  logic [10:0] lo_bits,
   output mm_dec_t     dec
);

   localparam int unsigned PO_W = 6;

   logic [PO_W-1:0] prim;
   logic [XO_W-1:0] xo;
   mm_op_e          op_sel;

   if (PRIMARY_OP >= (1 << PO_W)) begin : g_bad_prim
      $error("PRIMARY_OP does not fit the primary opcode field");
   end

   assign prim = hi_bits[10:5];
   assign xo   = lo_bits[10:1];

   always_comb begin
      op_sel = OPK_NONE;
      if (prim == PO_W'(PRIMARY_OP)) begin
         unique case (xo)
            XO_MAXU: op_sel = OPK_MAXU;
            XO_MINS: op_sel = OPK_MINS;
            XO_MINU: op_sel = OPK_MINU;
            XO_AVG:  op_sel = OPK_AVG;
            default: op_sel = OPK_NONE;
         endcase
      end
   end

   always_comb begin
      dec.op    = op_sel;
      dec.legal = (op_sel != OPK_NONE);
      dec.rec   = lo_bits[0];
      dec.rt    = hi_bits[4:0];
   end

endmodule

// File: rtl/mmavg_alu.sv
module mmavg_alu
   import mmavg_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter bit          SHARED_CMP = 1'b1
) (
   input  mm_op_e          op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res
);

   localparam int unsigned SUM_W = XLEN + 1;
   localparam int unsigned CMP_W = XLEN + 2;

   logic            is_signed;
   logic            a_lt_b;
   logic [SUM_W-1:0] avg_sum;
   logic [XLEN-1:0]  avg_res;

   if (XLEN < 2) begin : g_bad_xlen
      $error("XLEN must be at least 2");
   end

   assign is_signed = (op == OPK_MINS);

   if (SHARED_CMP) begin : g_cmp_shared
      logic [CMP_W-1:0] ax;
      logic [CMP_W-1:0] bx;
      logic [CMP_W-1:0] diff;
      assign ax     = {{2{is_signed & a[XLEN-1]}}, a};
      assign bx     = {{2{is_signed & b[XLEN-1]}}, b};
      assign diff   = ax - bx;
      assign a_lt_b = diff[CMP_W-1];
   end else begin : g_cmp_dual
      logic lt_s;
      logic lt_u;
      assign lt_s   = ($signed(a) < $signed(b));
      assign lt_u   = (a < b);
      assign a_lt_b = is_signed ? lt_s : lt_u;
   end

   assign avg_sum = {1'b0, a} + {1'b0, b} + SUM_W'(1);
   assign avg_res = avg_sum[SUM_W-1:1];

   always_comb begin
      unique case (op)
         OPK_MAXU: res = a_lt_b ? b : a;
         OPK_MINS: res = a_lt_b ? a : b;
         OPK_MINU: res = a_lt_b ? a : b;
         OPK_AVG:  res = avg_res;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/mmavg_cond.sv
module mmavg_cond
   import mmavg_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] value,
   input  logic            so,
   output logic [CR_W-1:0] field
);

   logic neg;
   logic zero;

   assign neg   = value[XLEN-1];
   assign zero  = (value == '0);
   assign field = {neg, ~neg & ~zero, zero, so};

endmodule

// File: rtl/mmavg_exec_unit.sv
module mmavg_exec_unit
   import mmavg_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned PRIMARY_OP = 22,
   parameter bit          SHARED_CMP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [INSN_W-1:0]    insn,
   input  logic [XLEN-1:0]      opnd_a,
   input  logic [XLEN-1:0]      opnd_b,
   input  logic                 so_in,
   output logic                 out_valid,
   output logic [REG_IDX_W-1:0] out_rt,
   output logic [XLEN-1:0]      out_result,
   output logic                 out_wen,
   output logic                 out_illegal,
   output logic                 out_cr_wen,
   output logic [CR_W-1:0]      out_cr
);

   mm_dec_t         dec;
   logic [XLEN-1:0] alu_res;
   logic [CR_W-1:0] cr_next;

   logic                 r_valid;
   logic [REG_IDX_W-1:0] r_rt;
   logic [XLEN-1:0]      r_res;
   logic                 r_wen;
   logic                 r_ill;
   logic                 r_crw;
   logic [CR_W-1:0]      r_cr;

   if (XLEN < 2) begin : g_bad_width
      $error("XLEN must be at least 2");
   end

   mmavg_decode #(
      .PRIMARY_OP(PRIMARY_OP)
   ) u_decode (
      .hi_bits(insn[31:21]),
      .lo_bits(insn[10:0]),
      .dec    (dec)
   );

   mmavg_alu #(
      .XLEN      (XLEN),
      .SHARED_CMP(SHARED_CMP)
   ) u_alu (
      .op (dec.op),
      .a  (opnd_a),
      .b  (opnd_b),
      .res(alu_res)
   );

   mmavg_cond #(
      .XLEN(XLEN)
   ) u_cond (
      .value(alu_res),
      .so   (so_in),
      .field(cr_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         r_valid <= 1'b0;
         r_wen   <= 1'b0;
         r_ill   <= 1'b0;
         r_crw   <= 1'b0;
         r_rt    <= '0;
         r_res   <= '0;
         r_cr    <= '0;
      end else begin
         r_valid <= in_valid;
         if (in_valid) begin
            r_rt  <= dec.rt;
            r_res <= alu_res;
            r_wen <= dec.legal;
            r_ill <= ~dec.legal;
            r_crw <= dec.legal & dec.rec;
            r_cr  <= cr_next;
         end
      end
   end

   assign out_valid   = r_valid;
   assign out_rt      = r_rt;
   assign out_result  = r_res;
   assign out_wen     = r_valid & r_wen;
   assign out_illegal = r_valid & r_ill;
   assign out_cr_wen  = r_valid & r_crw;
   assign out_cr      = r_cr;

   p_strobe_to_valid_r9 : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_idle_quiet_r9 : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_wen && !out_cr_wen && !out_illegal));
   p_illegal_no_write_r8 : assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (!out_wen && !out_cr_wen));
   p_cr_needs_write_r7 : assert property (@(posedge clk) disable iff (rst)
      out_cr_wen |-> out_wen);
   p_cr_one_relation_r6 : assert property (@(posedge clk) disable iff (rst)
      out_cr_wen |-> ($countones(out_cr[3:1]) == 1));
   p_avg_between_r5 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec.op == OPK_AVG) |->
         ((alu_res >= opnd_a || alu_res >= opnd_b) &&
          (alu_res <= opnd_a || alu_res <= opnd_b)));
   p_minu_bound_r4 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec.op == OPK_MINU) |->
         (alu_res <= opnd_a && alu_res <= opnd_b));
   p_maxu_bound_r2 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec.op == OPK_MAXU) |->
         (alu_res >= opnd_a && alu_res >= opnd_b));

endmodule

// File: tb/mmavg_exec_unit_bench.sv
module mmavg_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic        so_in = 1'b0;
   logic        out_valid;
   logic [4:0]  out_rt;
   logic [63:0] out_result;
   logic        out_wen;
   logic        out_illegal;
   logic        out_cr_wen;
   logic [3:0]  out_cr;

   int n_checks = 0;
   int n_fail = 0;

   bit          e_v = 1'b0;
   logic [4:0]  e_rt;
   logic [63:0] e_res;
   bit          e_legal;
   bit          e_crw;
   logic [3:0]  e_cr;
   string       e_tag = "R9";

   localparam logic [9:0] K_MAXU = 10'b0011001110;
   localparam logic [9:0] K_MINS = 10'b0101001110;
   localparam logic [9:0] K_MINU = 10'b0001001110;
   localparam logic [9:0] K_AVG  = 10'b1101001110;

   always #2 clk = ~clk;

   mmavg_exec_unit u_mmavg_exec_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .so_in(so_in),
      .out_valid(out_valid), .out_rt(out_rt), .out_result(out_result),
      .out_wen(out_wen), .out_illegal(out_illegal),
      .out_cr_wen(out_cr_wen), .out_cr(out_cr)
   );

   function automatic logic [31:0] mk(input logic [5:0] po, input logic [9:0] xo,
                                      input logic [4:0] rt, input logic rc);
      return {po, rt, 5'd7, 5'd9, xo, rc};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_now();
      chk(e_tag, "out_valid", 64'(out_valid), 64'(e_v));
      if (e_v) begin
         chk(e_tag, "out_illegal", 64'(out_illegal), 64'(!e_legal));
         chk(e_tag, "out_wen", 64'(out_wen), 64'(e_legal));
         chk(e_tag, "out_cr_wen", 64'(out_cr_wen), 64'(e_crw));
         chk(e_tag, "out_result", out_result, e_res);
         if (e_legal) chk(e_tag, "out_rt", 64'(out_rt), 64'(e_rt));
         if (e_crw) chk(e_tag, "out_cr", 64'(out_cr), 64'(e_cr));
      end else begin
         chk(e_tag, "idle out_wen", 64'(out_wen), 64'd0);
         chk(e_tag, "idle out_cr_wen", 64'(out_cr_wen), 64'd0);
         chk(e_tag, "idle out_illegal", 64'(out_illegal), 64'd0);
      end
   endtask

   task automatic tick(input bit v, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input bit so, input string tag);
      logic [63:0] r;
      bit lg;
      @(negedge clk);
      compare_now();
      in_valid = v; insn = w; opnd_a = a; opnd_b = b; so_in = so;
      lg = (w[31:26] == 6'd22) &&
           (w[10:1] == K_MAXU || w[10:1] == K_MINS ||
            w[10:1] == K_MINU || w[10:1] == K_AVG);
      r = '0;
      if (lg) begin
         if (w[10:1] == K_MAXU) r = (a > b) ? a : b;
         else if (w[10:1] == K_MINU) r = (a < b) ? a : b;
         else if (w[10:1] == K_MINS) r = ($signed(a) < $signed(b)) ? a : b;
         else r = (a >> 1) + (b >> 1) + 64'(a[0] | b[0]);
      end
      e_v = v; e_rt = w[25:21]; e_res = r; e_legal = lg;
      e_crw = lg && w[0];
      e_cr = {r[63], !r[63] && (r != 0), r == 0, so};
      e_tag = tag;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R10: outputs cleared by reset
      chk("R10", "reset out_valid", 64'(out_valid), 64'd0);
      chk("R10", "reset out_wen", 64'(out_wen), 64'd0);
      chk("R10", "reset out_cr_wen", 64'(out_cr_wen), 64'd0);
      chk("R10", "reset out_illegal", 64'(out_illegal), 64'd0);

      // R5 average vectors, back to back (R9)
      tick(1, mk(6'd22, K_AVG, 5'd3, 1'b0), 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 0, "R5");
      tick(1, mk(6'd22, K_AVG, 5'd3, 1'b0), 64'hc523e996a8ff6214, 64'he1e5b9cc9864c4a8, 0, "R5");
      tick(1, mk(6'd22, K_AVG, 5'd3, 1'b0), 64'hc523e996a8ff6213, 64'he1e5b9cc9864c4a8, 0, "R5");
      tick(1, mk(6'd22, K_AVG, 5'd4, 1'b1), 64'hffffffffffffffff, 64'hffffffffffffffff, 0, "R5");
      tick(1, mk(6'd22, K_AVG, 5'd4, 1'b0), 64'h0, 64'h1, 0, "R5");
      // R2 unsigned max
      tick(1, mk(6'd22, K_MAXU, 5'd1, 1'b0), 64'h8000000000000000, 64'h7fffffffffffffff, 0, "R2");
      tick(1, mk(6'd22, K_MAXU, 5'd1, 1'b0), 64'h5, 64'h9, 0, "R2");
      // R3 signed min
      tick(1, mk(6'd22, K_MINS, 5'd2, 1'b0), 64'h8000000000000000, 64'h7fffffffffffffff, 0, "R3");
      tick(1, mk(6'd22, K_MINS, 5'd2, 1'b0), 64'hfffffffffffffffe, 64'hffffffffffffffff, 0, "R3");
      tick(1, mk(6'd22, K_MINS, 5'd2, 1'b0), 64'h10, 64'h3, 0, "R3");
      // R4 unsigned min
      tick(1, mk(6'd22, K_MINU, 5'd5, 1'b0), 64'h8000000000000000, 64'h7fffffffffffffff, 0, "R4");
      tick(1, mk(6'd22, K_MINU, 5'd5, 1'b0), 64'h2, 64'hffffffffffffffff, 0, "R4");
      // R6 condition field: negative, zero, positive, with SO
      tick(1, mk(6'd22, K_MINS, 5'd6, 1'b1), 64'hffffffffffff0000, 64'h1, 0, "R6");
      tick(1, mk(6'd22, K_MINU, 5'd6, 1'b1), 64'h0, 64'h1234, 1, "R6");
      tick(1, mk(6'd22, K_MAXU, 5'd6, 1'b1), 64'h42, 64'h17, 1, "R6");
      // R7 record bit clear
      tick(1, mk(6'd22, K_MINS, 5'd8, 1'b0), 64'hffffffffffff0000, 64'h1, 1, "R7");
      // R8 illegal encodings
      tick(1, mk(6'd31, K_AVG, 5'd9, 1'b1), 64'h3, 64'h5, 0, "R8");
      tick(1, mk(6'd22, 10'b1001001110, 5'd9, 1'b1), 64'h3, 64'h5, 0, "R8");
      tick(1, mk(6'd23, K_MAXU, 5'd9, 1'b0), 64'h3, 64'h5, 0, "R8");
      // R1 destination index at both ends of the field
      tick(1, mk(6'd22, K_MAXU, 5'd31, 1'b0), 64'h1, 64'h2, 0, "R1");
      tick(1, mk(6'd22, K_MAXU, 5'd0, 1'b0), 64'h1, 64'h2, 0, "R1");
      // R9 idle gaps between strobes
      tick(0, mk(6'd22, K_AVG, 5'd3, 1'b1), 64'h0, 64'h0, 0, "R9");
      tick(0, 32'h0, 64'h0, 64'h0, 0, "R9");
      tick(1, mk(6'd22, K_AVG, 5'd12, 1'b1), 64'h7fffffffffffffff, 64'h1, 0, "R9");
      tick(0, 32'h0, 64'h0, 64'h0, 0, "R9");
      tick(0, 32'h0, 64'h0, 64'h0, 0, "R9");

      // R10 reset mid-stream clears a pending result
      tick(1, mk(6'd22, K_MAXU, 5'd3, 1'b1), 64'h1, 64'h2, 0, "R10");
      rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b0;
      chk("R10", "mid reset out_valid", 64'(out_valid), 64'd0);
      chk("R10", "mid reset out_wen", 64'(out_wen), 64'd0);
      chk("R10", "mid reset out_cr_wen", 64'(out_cr_wen), 64'd0);
      e_v = 1'b0; e_tag = "R10";
      tick(0, 32'h0, 64'h0, 64'h0, 0, "R10");
      tick(0, 32'h0, 64'h0, 64'h0, 0, "R10");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule